// File: doc/BRIEF.md
# Interlaced Field Parity Detector

This block tells an on-screen display whether the current interlaced field is odd or even. It takes the raw horizontal and vertical sync signals. Each one has its own polarity switch, so the signals are first normalised to active-high form. The block then counts sample-clock cycles from the latest active horizontal edge to the active vertical edge. At each vertical edge it compares that offset with the offset it stored for the field before. A longer offset marks an even field and a shorter one marks an odd field.

A byte-wide control/status register holds the two input polarity switches, two output polarity switches (one for the three colour outputs and one for a single auxiliary output) and a dot-line select bit. The register also reflects the field flag in a read-only position. The block outputs the dot line (0 or 1) that a half-line-high renderer draws in the current field. Because the field parity changes every field, this dot line changes with it. Clock generation, bus decoding and the renderer itself are outside the block.

Top module: `field_parity_detector`

## Requirements
- R1: After a synchronous active-low reset, the register reads 0x00, `field_odd` is 0, `field_strobe` is 0 and `dot_line` is 0.
- R2: Register bit 0 sets the horizontal sync polarity and bit 1 sets the vertical sync polarity. With the bit at 0 the rising edge of the raw input is the active edge; with the bit at 1 the falling edge is active.
- R3: The measured offset is the number of clock cycles from the most recent active horizontal edge to the active vertical edge. When both raw edges pass through the same synchronizer, an input separation of d cycles gives an offset of d-1. The offset counter clears on every active horizontal edge and holds at 2^CNT_W-1 instead of wrapping.
- R4: When the new offset is larger than the stored one, the field is even and `field_odd` and register bit 6 become 0. When the new offset is smaller, the field is odd and both become 1.
- R5: When the new offset equals the stored one, the field flag keeps its value. The new offset always replaces the stored one.
- R6: Each detected vertical edge produces exactly one `field_strobe` pulse, one cycle wide. The field flag changes only in the cycle in which that strobe is high.
- R7: Register bits 0, 1, 2, 3 and 5 read back the value last written. Bits 4 and 7 always read 0. Bit 6 is read-only: it shows the field flag, and a write to it has no effect.
- R8: With register bit 5 at 0, `dot_line` equals `field_odd` (line 0 in even fields, line 1 in odd fields). With bit 5 at 1 the mapping is inverted. Bit 5 never changes the field flag.
- R9: With register bit 2 at 1, `rgb_out` is the bitwise inverse of `rgb_in`, and with it at 0 the two are equal. Register bit 3 controls `out1_out` from `out1_in` in the same way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_raw | input | 1 | Raw horizontal sync input |
| vsync_raw | input | 1 | Raw vertical sync input |
| reg_wr_en | input | 1 | Write strobe for the control/status register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Register read value |
| rgb_in | input | RGB_W | Colour outputs from the renderer |
| out1_in | input | 1 | Auxiliary output from the renderer |
| rgb_out | output | RGB_W | Colour outputs after the polarity switch |
| out1_out | output | 1 | Auxiliary output after the polarity switch |
| field_odd | output | 1 | Field flag: 1 odd, 0 even |
| field_strobe | output | 1 | One-cycle pulse when the field flag is evaluated |
| dot_line | output | 1 | Dot line to draw in the current field |

## Verification
The assertions check the following on every cycle: the counter clears and saturates, each comparison outcome (longer, shorter, equal) lands in the flag, the strobe is one cycle wide and the flag never moves without it, the reserved bits are zero, the writable bits read back, and `dot_line` follows flag changes. Only the bench's scenarios can show the end-to-end results. These are that a given raw-pin separation gives the right parity sequence, that the falling-edge polarities really change which edges are measured (checked with asymmetric pulse widths), and that a very long offset behaves as saturated and not wrapped. The output inversion and the read-only flag bit are also checked at the ports by the bench.

// File: rtl/fpd_pkg.sv
// Package: shared control-field type and bit positions for the field parity
// detector. Assumes an 8-bit control/status register.
package fpd_pkg;

    localparam int REG_W        = 8;
    localparam int BIT_HS_NEG   = 0;
    localparam int BIT_VS_NEG   = 1;
    localparam int BIT_RGB_NEG  = 2;
    localparam int BIT_OUT1_NEG = 3;
    localparam int BIT_DOT_SEL  = 5;
    localparam int BIT_FIELD    = 6;

    localparam int CH_H   = 0;
    localparam int CH_V   = 1;
    localparam int NUM_CH = 2;

    typedef struct packed {
        logic dot_sel;
        logic out1_neg;
        logic rgb_neg;
        logic vs_neg;
        logic hs_neg;
    } ctrl_t;

endpackage

// File: rtl/fpd_sync_edge.sv
// Module: synchronizes one raw sync input, normalises it to active-high using
// its polarity switch, and pulses for one cycle on the active edge.
// Assumes SYNC_STAGES >= 2 and that the polarity switch is quasi-static.
module fpd_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic active_low,
    output logic edge_pulse
);

    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   norm;
    logic                   norm_q;

    // Shift the raw input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[TOP-1:0], raw_in};
    end

    // Normalise polarity so that the active level is always 1.
    always_comb norm = chain_q[TOP] ^ active_low;

    // Keep the previous normalised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) norm_q <= 1'b0;
        else        norm_q <= norm;
    end

    // Active edge: normalised level rose in this cycle.
    always_comb edge_pulse = norm & ~norm_q;

    p_edge_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        edge_pulse |=> !edge_pulse)
        else $error("p_edge_single_r6: edge pulse longer than one cycle");

endmodule

// File: rtl/fpd_field_judge.sv
// Module: measures cycles from the latest horizontal edge to the vertical
// edge, compares with the previous field's measurement and keeps the field
// flag. Assumes one-cycle edge pulses from the synchronizer stage.
module fpd_field_judge #(
    parameter int CNT_W = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic h_edge,
    input  logic v_edge,
    output logic field_odd,
    output logic field_strobe
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] offset_q;
    logic [CNT_W-1:0] prev_q;

    // Offset counter: clear on horizontal edge, saturate at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)                 offset_q <= '0;
        else if (h_edge)            offset_q <= '0;
        else if (offset_q != CNT_MAX) offset_q <= offset_q + 1'b1;
    end

    // Field decision at each vertical edge; store this field's offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q       <= '0;
            field_odd    <= 1'b0;
            field_strobe <= 1'b0;
        end else begin
            field_strobe <= v_edge;
            if (v_edge) begin
                prev_q <= offset_q;
                if (offset_q > prev_q)      field_odd <= 1'b0;
                else if (offset_q < prev_q) field_odd <= 1'b1;
            end
        end
    end

    p_cnt_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        h_edge |=> (offset_q == '0))
        else $error("p_cnt_clear_r3");

    p_cnt_saturate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (offset_q == CNT_MAX && !h_edge) |=> (offset_q == CNT_MAX))
        else $error("p_cnt_saturate_r3");

    p_longer_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (v_edge && offset_q > prev_q) |=> !field_odd)
        else $error("p_longer_even_r4");

    p_shorter_odd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (v_edge && offset_q < prev_q) |=> field_odd)
        else $error("p_shorter_odd_r4");

    p_equal_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (v_edge && offset_q == prev_q) |=> $stable(field_odd))
        else $error("p_equal_keep_r5");

    p_store_new_r5: assert property (@(posedge clk) disable iff (!rst_n)
        v_edge |=> (prev_q == $past(offset_q)))
        else $error("p_store_new_r5");

    p_flag_with_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field_odd) |-> field_strobe)
        else $error("p_flag_with_strobe_r6");

    p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        field_strobe |=> !field_strobe)
        else $error("p_strobe_single_r6");

endmodule

// File: rtl/fpd_ctrl_reg.sv
// Module: byte-wide control/status register. Holds the polarity switches
// and the dot-line select, and reflects the field flag read-only.
// Assumes a single-cycle write strobe from an external decoder.
module fpd_ctrl_reg
    import fpd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             field_odd,
    output logic [REG_W-1:0] rdata,
    output ctrl_t            ctrl
);

    localparam logic [REG_W-1:0] RW_MASK = REG_W'((1 << BIT_HS_NEG) | (1 << BIT_VS_NEG) |
                                                  (1 << BIT_RGB_NEG) | (1 << BIT_OUT1_NEG) |
                                                  (1 << BIT_DOT_SEL));

    // Capture writable fields on a write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_en) begin
            ctrl.hs_neg   <= wdata[BIT_HS_NEG];
            ctrl.vs_neg   <= wdata[BIT_VS_NEG];
            ctrl.rgb_neg  <= wdata[BIT_RGB_NEG];
            ctrl.out1_neg <= wdata[BIT_OUT1_NEG];
            ctrl.dot_sel  <= wdata[BIT_DOT_SEL];
        end
    end

    // Assemble the read value; reserved bits stay zero.
    always_comb begin
        rdata               = '0;
        rdata[BIT_HS_NEG]   = ctrl.hs_neg;
        rdata[BIT_VS_NEG]   = ctrl.vs_neg;
        rdata[BIT_RGB_NEG]  = ctrl.rgb_neg;
        rdata[BIT_OUT1_NEG] = ctrl.out1_neg;
        rdata[BIT_DOT_SEL]  = ctrl.dot_sel;
        rdata[BIT_FIELD]    = field_odd;
    end

    p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[4] == 1'b0) && (rdata[7] == 1'b0))
        else $error("p_reserved_zero_r7");

    p_write_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((rdata & RW_MASK) == ($past(wdata) & RW_MASK)))
        else $error("p_write_readback_r7");

    p_hold_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((rdata & RW_MASK) == ($past(rdata) & RW_MASK)))
        else $error("p_hold_no_write_r7");

endmodule

// File: rtl/field_parity_detector.sv
// Module: top of the interlaced field parity detector. Normalises and
// edge-detects both sync inputs, judges field parity, exposes the control/
// status register, applies output polarity and selects the dot line.
// Assumes sync inputs are asynchronous to clk and polarity changes are rare.
module field_parity_detector
    import fpd_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int SYNC_STAGES = 2,
    parameter int RGB_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_raw,
    input  logic             vsync_raw,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [RGB_W-1:0] rgb_in,
    input  logic             out1_in,
    output logic [RGB_W-1:0] rgb_out,
    output logic             out1_out,
    output logic             field_odd,
    output logic             field_strobe,
    output logic             dot_line
);

    ctrl_t             ctrl;
    logic [NUM_CH-1:0] raw_vec;
    logic [NUM_CH-1:0] neg_vec;
    logic [NUM_CH-1:0] edge_vec;

    // Gather per-channel inputs and polarity switches.
    always_comb begin
        raw_vec[CH_H] = hsync_raw;
        raw_vec[CH_V] = vsync_raw;
        neg_vec[CH_H] = ctrl.hs_neg;
        neg_vec[CH_V] = ctrl.vs_neg;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_sync
        fpd_sync_edge #(
            .SYNC_STAGES(SYNC_STAGES)
        ) sync_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .raw_in    (raw_vec[ch]),
            .active_low(neg_vec[ch]),
            .edge_pulse(edge_vec[ch])
        );
    end

    fpd_field_judge #(
        .CNT_W(CNT_W)
    ) judge_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .h_edge      (edge_vec[CH_H]),
        .v_edge      (edge_vec[CH_V]),
        .field_odd   (field_odd),
        .field_strobe(field_strobe)
    );

    fpd_ctrl_reg reg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wdata    (reg_wdata),
        .field_odd(field_odd),
        .rdata    (reg_rdata),
        .ctrl     (ctrl)
    );

    // Output polarity switches and field-dependent dot-line choice.
    always_comb begin
        rgb_out  = rgb_in ^ {RGB_W{ctrl.rgb_neg}};
        out1_out = out1_in ^ ctrl.out1_neg;
        dot_line = field_odd ^ ctrl.dot_sel;
    end

    p_dot_follows_field_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(field_odd) && $stable(reg_rdata[BIT_DOT_SEL])) |-> !$stable(dot_line))
        else $error("p_dot_follows_field_r8");

endmodule

// File: tb/field_parity_detector_tb_top.sv
module field_parity_detector_tb_top;

    localparam int CNT_W = 6;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync_raw = 1'b0;
    logic       vsync_raw = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [2:0] rgb_in = 3'b000;
    logic       out1_in = 1'b0;
    logic [2:0] rgb_out;
    logic       out1_out;
    logic       field_odd;
    logic       field_strobe;
    logic       dot_line;

    always #2 clk = ~clk;

    field_parity_detector #(.CNT_W(CNT_W), .SYNC_STAGES(2), .RGB_W(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .hsync_raw(hsync_raw), .vsync_raw(vsync_raw),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rgb_in(rgb_in), .out1_in(out1_in), .rgb_out(rgb_out), .out1_out(out1_out),
        .field_odd(field_odd), .field_strobe(field_strobe), .dot_line(dot_line)
    );

    typedef struct { bit care; bit odd; } exp_t;
    exp_t q[$];

    int n_chk = 0;
    int n_bad = 0;
    bit b_hneg = 0, b_vneg = 0, b_sel = 0;
    int m_prev = 0;
    bit m_odd = 0;
    bit m_known = 1;
    bit last_strobe = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        b_sel = d[5];
    endtask

    // Driver: model the field decision, push it, then drive the pins.
    task automatic run_field(input int d, input int hw, input int vw, input bit care);
        int   meas;
        exp_t e;
        meas = (d - 1 > CMAX) ? CMAX : d - 1;
        if (care && m_known) begin
            if (meas > m_prev)      m_odd = 1'b0;
            else if (meas < m_prev) m_odd = 1'b1;
            e.care = 1'b1;
        end else begin
            e.care  = 1'b0;
            m_known = 1'b0;
        end
        if (!m_known && care && meas != m_prev) begin
            m_odd   = (meas < m_prev);
            m_known = 1'b1;
            e.care  = 1'b1;
        end
        if (!care) m_known = 1'b0;
        if (!care) e.care = 1'b0;
        e.odd  = m_odd;
        m_prev = meas;
        q.push_back(e);
        // earlier line edge, superseded by the next one (R3)
        hsync_raw = ~b_hneg; idle(2); hsync_raw = b_hneg; idle(5);
        hsync_raw = ~b_hneg; idle(hw); hsync_raw = b_hneg;
        idle(d - hw);
        vsync_raw = ~b_vneg; idle(vw); vsync_raw = b_vneg;
        idle(12);
    endtask

    // Monitor: pop and compare at each strobe.
    always @(negedge clk) begin
        if (rst_n) begin
            if (field_strobe && last_strobe)
                chk(1'b0, "R6 strobe wider than one cycle", 1, 0);
            if (field_strobe) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R6 unexpected strobe", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (e.care) begin
                        chk(field_odd == e.odd, "R4/R5 field_odd", field_odd, e.odd);
                        chk(reg_rdata[6] == e.odd, "R7 flag bit6", reg_rdata[6], e.odd);
                        chk(dot_line == (e.odd ^ b_sel), "R8 dot_line", dot_line, e.odd ^ b_sel);
                    end
                end
            end
            last_strobe = field_strobe;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad + 0);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk(reg_rdata == 8'h00, "R1 reg reset", reg_rdata, 8'h00);
        chk(field_odd == 1'b0, "R1 field_odd reset", field_odd, 0);
        chk(field_strobe == 1'b0, "R1 strobe reset", field_strobe, 0);
        chk(dot_line == 1'b0, "R1 dot_line reset", dot_line, 0);

        // R2/R4/R5 positive polarity sequence
        run_field(20, 2, 3, 1);   // 19 > 0  : even
        run_field(10, 2, 3, 1);   // 9 < 19  : odd
        run_field(10, 2, 3, 1);   // equal   : keep odd (R5)
        run_field(30, 2, 3, 1);   // 29 > 9  : even
        run_field(30, 2, 3, 1);   // equal   : keep even (R5)
        run_field(12, 2, 3, 1);   // odd
        run_field(15, 2, 3, 1);   // even

        // R3 saturation: both saturate to CMAX, so equal keeps the flag
        run_field(100, 2, 3, 1);  // 63 > 14 : even
        run_field(150, 2, 3, 1);  // 63 == 63: keep even (wrap would read 21)
        run_field(40, 2, 3, 1);   // 39 < 63 : odd
        chk(field_odd == m_odd, "R3 after saturation", field_odd, m_odd);

        // R7/R8/R9 register behaviour, polarities untouched
        rgb_in  = 3'b101;
        out1_in = 1'b1;
        wr(8'hFC);
        idle(1);
        chk(reg_rdata == (8'h2C | (8'(m_odd) << 6)), "R7 readback and reserved", reg_rdata,
            8'h2C | (8'(m_odd) << 6));
        chk(field_odd == m_odd, "R7 bit6 write ignored", field_odd, m_odd);
        chk(dot_line == (m_odd ^ 1'b1), "R8 select inverts line", dot_line, m_odd ^ 1'b1);
        chk(rgb_out == 3'b010, "R9 rgb inverted", rgb_out, 3'b010);
        chk(out1_out == 1'b0, "R9 out1 inverted", out1_out, 0);
        run_field(60, 2, 3, 1);   // 59 > 39 : even, with select=1
        wr(8'h40);
        idle(1);
        chk(reg_rdata == (8'(m_odd) << 6), "R7 bit6 write ignored after clear", reg_rdata,
            8'(m_odd) << 6);
        chk(rgb_out == 3'b101, "R9 rgb passthrough", rgb_out, 3'b101);
        chk(out1_out == 1'b1, "R9 out1 passthrough", out1_out, 1);
        chk(dot_line == m_odd, "R8 select zero", dot_line, m_odd);

        // R2 switch both inputs to negative polarity: one spurious update
        begin
            exp_t e;
            e.care = 1'b0; e.odd = 1'b0;
            q.push_back(e);
        end
        m_known = 1'b0;
        wr(8'h03);
        b_hneg = 1'b1; b_vneg = 1'b1;
        idle(8);
        hsync_raw = 1'b1; vsync_raw = 1'b1;
        idle(10);
        chk(reg_rdata[1:0] == 2'b11, "R2 polarity bits", reg_rdata[1:0], 2'b11);
        // falling edges active; wide vertical pulse exposes wrong-edge use
        run_field(25, 2, 3, 0);   // prime: stores 24
        run_field(20, 2, 20, 1);  // 19 < 24 : odd (rising edges would say even)
        run_field(35, 30, 3, 1);  // 34 > 19 : even (rising edges would say odd)
        run_field(8, 2, 3, 1);    // 7 < 34  : odd

        idle(20);
        chk(q.size() == 0, "R6 all fields strobed", q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule